// File: doc/BRIEF.md
# PHY Reset and Shutdown Sequencer

This block brings a CSI-2 D-PHY and its receiver core out of reset in a fixed order, in hardware. A one-cycle start command first holds the receiver core in reset. It then drives the PHY reset, the PHY shutdown and the test-clear line low. After a minimum low time it raises test-clear. It then releases shutdown, releases the PHY reset, and finally releases the core reset. Each release step is followed by a minimum gap. All minimum times are given in nanoseconds. They are turned into clock cycles by rounding up against a clock-period parameter given in picoseconds.

A stop command puts the receiver core back into reset. A small register port lets software read each of the four control lines and overwrite it. Writes that arrive while the sequence runs are held back and applied once it has finished, so the ordering is never broken.

Top module: `phy_rst_seq`

## Requirements
- R1: After reset, all four control outputs (test-clear, shutdown_n, PHY reset_n, core reset_n) are low, and busy and done are low.
- R2: A start sampled while idle drives core reset_n low one cycle later and raises busy in that same cycle. One cycle after that, PHY reset_n, shutdown_n and test-clear are all low.
- R3: Test-clear stays low for TCLR_CYC = ceil(15000 / CLK_PERIOD_PS) cycles and then goes high. This is 4 cycles at the default period of 4000 ps.
- R4: Shutdown_n goes high one cycle after test-clear rises. PHY reset_n goes high GAP_CYC = ceil(5000 / CLK_PERIOD_PS) cycles after that. This is 2 cycles at the default period.
- R5: Core reset_n goes high GAP_CYC cycles after PHY reset_n rises. In that same cycle done is high for exactly one cycle and busy falls.
- R6: A start sampled while busy is ignored, and the running timeline is unchanged.
- R7: A stop sampled while idle drives core reset_n low one cycle later and leaves the other outputs unchanged. When start and stop are sampled together while idle, start takes effect.
- R8: A register write while idle updates the addressed line from wdata bit 0, one cycle later. The offsets are 0x08 for core reset_n, 0x40 for shutdown_n, 0x44 for PHY reset_n and 0x50 for test-clear. A write to any other offset changes nothing.
- R9: Writes sampled while busy are held. Each field keeps its most recent value, and all held fields are applied one cycle after busy falls.
- R10: Read data is combinational. Bit 0 holds the current value of the line at a mapped offset, and every other bit is 0. An unmapped offset reads 0.
- R11: A write sampled in the same cycle as an accepted start is treated as a write during busy and is deferred as in R9.
- R12: A stop sampled while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_start | input | 1 | Start the bring-up sequence |
| seq_stop | input | 1 | Put the receiver core back into reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Write data, bit 0 used |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| phy_test_clr | output | 1 | PHY test-clear line |
| phy_shutdown_n | output | 1 | PHY shutdown, active low |
| phy_rst_n | output | 1 | PHY reset, active low |
| core_rst_n | output | 1 | Receiver core reset, active low |
| seq_busy | output | 1 | Sequence in progress |
| seq_done | output | 1 | One-cycle pulse at the end of the sequence |

## Verification
Two kinds of collision are tested: a register write in the same cycle as an accepted start, and writes made while the timed release steps are still running. The bench provokes the first by raising start and the write strobe at the same edge. It provokes the second with several writes to the same field during the run, the last one being the value that should win. In both cases the scoreboard expects the full timeline to run without any disturbance, followed by an extra entry one cycle after done that carries only the held values. A start and a stop issued in the middle of a run check that the timeline ignores them.

// File: rtl/phy_rst_seq_pkg.sv
package phy_rst_seq_pkg;

    typedef struct packed {
        logic tclr;
        logic phy_rst_n;
        logic shut_n;
        logic ctl_rst_n;
    } pctl_t;

    localparam int NFIELD = 4;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_CORE_LO,
        SQ_CLR_LO,
        SQ_SHUT_UP,
        SQ_SHUT_GAP,
        SQ_PHY_GAP
    } sq_state_e;

    localparam logic [7:0] OFS_CTL   = 8'h08;
    localparam logic [7:0] OFS_SHUT  = 8'h40;
    localparam logic [7:0] OFS_PHY   = 8'h44;
    localparam logic [7:0] OFS_TCTL0 = 8'h50;

    function automatic int ns_to_cycles(input int ns, input int period_ps);
        int c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic logic [NFIELD-1:0] field_sel(input logic [7:0] a);
        case (a)
            OFS_CTL:   return 4'b0001;
            OFS_SHUT:  return 4'b0010;
            OFS_PHY:   return 4'b0100;
            OFS_TCTL0: return 4'b1000;
            default:   return 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)              cnt_q <= '0;
        else if (load)        cnt_q <= load_val;
        else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

    // R3
    timer_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/seq_regs.sv
module seq_regs
    import phy_rst_seq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack,
    input  pctl_t             cur,
    output logic [NFIELD-1:0] req_mask,
    output pctl_t             req_val,
    output logic [DATA_W-1:0] rdata
);
    logic [NFIELD-1:0] in_mask;
    logic [NFIELD-1:0] pend_mask_q;
    logic [NFIELD-1:0] pend_val_q;
    logic [NFIELD-1:0] merged_val;
    logic [NFIELD-1:0] rd_sel;
    logic [7:0]        addr8;
    logic              unused_hi;

    assign addr8     = 8'(addr);
    assign in_mask   = wr_en ? field_sel(addr8) : '0;
    assign rd_sel    = field_sel(addr8);
    assign unused_hi = ^wdata[DATA_W-1:1];

    for (genvar i = 0; i < NFIELD; i++) begin : g_field
        assign merged_val[i] = in_mask[i] ? wdata[0] : pend_val_q[i];

        always_ff @(posedge clk) begin
            if (rst || ack) begin
                pend_mask_q[i] <= 1'b0;
                pend_val_q[i]  <= 1'b0;
            end else if (in_mask[i]) begin
                pend_mask_q[i] <= 1'b1;
                pend_val_q[i]  <= wdata[0];
            end
        end
    end

    assign req_mask = pend_mask_q | in_mask;
    assign req_val  = pctl_t'(merged_val);

    always_comb begin
        rdata    = '0;
        rdata[0] = |(rd_sel & cur);
    end

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!ack && pend_mask_q != '0) |=> ((pend_mask_q & $past(pend_mask_q)) == $past(pend_mask_q)));
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
    import phy_rst_seq_pkg::*;
#(
    parameter int TCLR_CYC = 4,
    parameter int GAP_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic [NFIELD-1:0] req_mask,
    input  pctl_t             req_val,
    output pctl_t             cur,
    output logic              ack,
    output logic              busy,
    output logic              done
);
    localparam int MAXC  = (TCLR_CYC > GAP_CYC) ? TCLR_CYC : GAP_CYC;
    localparam int CNT_W = $clog2(MAXC + 1);

    sq_state_e        state_q, state_d;
    pctl_t            cur_q, cur_d;
    logic             done_q, done_d;
    logic             ld;
    logic [CNT_W-1:0] ld_val;
    logic             expired;

    seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (ld),
        .load_val (ld_val),
        .expired  (expired)
    );

    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        done_d  = 1'b0;
        ld      = 1'b0;
        ld_val  = '0;
        ack     = 1'b0;
        case (state_q)
            SQ_IDLE: begin
                if (start) begin
                    cur_d.ctl_rst_n = 1'b0;
                    state_d         = SQ_CORE_LO;
                end else begin
                    ack = 1'b1;
                    for (int i = 0; i < NFIELD; i++)
                        if (req_mask[i]) cur_d[i] = req_val[i];
                    if (stop) cur_d.ctl_rst_n = 1'b0;
                end
            end
            SQ_CORE_LO: begin
                cur_d.phy_rst_n = 1'b0;
                cur_d.shut_n    = 1'b0;
                cur_d.tclr      = 1'b0;
                ld              = 1'b1;
                ld_val          = CNT_W'(TCLR_CYC - 1);
                state_d         = SQ_CLR_LO;
            end
            SQ_CLR_LO: begin
                if (expired) begin
                    cur_d.tclr = 1'b1;
                    state_d    = SQ_SHUT_UP;
                end
            end
            SQ_SHUT_UP: begin
                cur_d.shut_n = 1'b1;
                ld           = 1'b1;
                ld_val       = CNT_W'(GAP_CYC - 1);
                state_d      = SQ_SHUT_GAP;
            end
            SQ_SHUT_GAP: begin
                if (expired) begin
                    cur_d.phy_rst_n = 1'b1;
                    ld              = 1'b1;
                    ld_val          = CNT_W'(GAP_CYC - 1);
                    state_d         = SQ_PHY_GAP;
                end
            end
            SQ_PHY_GAP: begin
                if (expired) begin
                    cur_d.ctl_rst_n = 1'b1;
                    done_d          = 1'b1;
                    state_d         = SQ_IDLE;
                end
            end
            default: state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            cur_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            done_q  <= done_d;
        end
    end

    assign cur  = cur_q;
    assign busy = (state_q != SQ_IDLE);
    assign done = done_q;

    logic [CNT_W-1:0] clr_lo_cnt, shut_hi_cnt, phy_hi_cnt;
    always_ff @(posedge clk) begin
        if (rst) begin
            clr_lo_cnt  <= '0;
            shut_hi_cnt <= '0;
            phy_hi_cnt  <= '0;
        end else begin
            clr_lo_cnt  <= cur_q.tclr ? '0 :
                           (clr_lo_cnt == CNT_W'(MAXC) ? clr_lo_cnt : clr_lo_cnt + 1'b1);
            shut_hi_cnt <= !cur_q.shut_n ? '0 :
                           (shut_hi_cnt == CNT_W'(MAXC) ? shut_hi_cnt : shut_hi_cnt + 1'b1);
            phy_hi_cnt  <= !cur_q.phy_rst_n ? '0 :
                           (phy_hi_cnt == CNT_W'(MAXC) ? phy_hi_cnt : phy_hi_cnt + 1'b1);
        end
    end

    // R2
    busy_core_lo_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !cur_q.ctl_rst_n);
    // R3
    clr_width_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(cur_q.tclr) && state_q == SQ_SHUT_UP) |-> (clr_lo_cnt >= CNT_W'(TCLR_CYC)));
    // R4
    shut_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(cur_q.phy_rst_n) && state_q == SQ_PHY_GAP) |-> (cur_q.shut_n && shut_hi_cnt >= CNT_W'(GAP_CYC)));
    // R5
    done_release_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (cur_q == 4'b1111 && !busy && phy_hi_cnt >= CNT_W'(GAP_CYC)));
    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
endmodule

// File: rtl/phy_rst_seq.sv
module phy_rst_seq
    import phy_rst_seq_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 4000,
    parameter int TCLR_MIN_NS   = 15,
    parameter int GAP_MIN_NS    = 5,
    parameter int ADDR_W        = 8,
    parameter int DATA_W        = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seq_start,
    input  logic              seq_stop,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              phy_test_clr,
    output logic              phy_shutdown_n,
    output logic              phy_rst_n,
    output logic              core_rst_n,
    output logic              seq_busy,
    output logic              seq_done
);
    localparam int TCLR_CYC = ns_to_cycles(TCLR_MIN_NS, CLK_PERIOD_PS);
    localparam int GAP_CYC  = ns_to_cycles(GAP_MIN_NS, CLK_PERIOD_PS);

    pctl_t             cur;
    pctl_t             req_val;
    logic [NFIELD-1:0] req_mask;
    logic              ack;

    seq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .ack      (ack),
        .cur      (cur),
        .req_mask (req_mask),
        .req_val  (req_val),
        .rdata    (reg_rdata)
    );

    seq_fsm #(.TCLR_CYC(TCLR_CYC), .GAP_CYC(GAP_CYC)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .start    (seq_start),
        .stop     (seq_stop),
        .req_mask (req_mask),
        .req_val  (req_val),
        .cur      (cur),
        .ack      (ack),
        .busy     (seq_busy),
        .done     (seq_done)
    );

    assign phy_test_clr   = cur.tclr;
    assign phy_shutdown_n = cur.shut_n;
    assign phy_rst_n      = cur.phy_rst_n;
    assign core_rst_n     = cur.ctl_rst_n;
endmodule

// File: tb/phy_rst_seq_tb.sv
module phy_rst_seq_tb;
    localparam int PERIOD_PS = 4000;
    localparam int T = (15000 + PERIOD_PS - 1) / PERIOD_PS;
    localparam int G = (5000 + PERIOD_PS - 1) / PERIOD_PS;
    localparam int E = 2 + T + 2 * G;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        seq_start = 1'b0, seq_stop = 1'b0, reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        phy_test_clr, phy_shutdown_n, phy_rst_n, core_rst_n, seq_busy, seq_done;

    always #(PERIOD_PS / 2 * 1ps) clk = ~clk;

    phy_rst_seq #(.CLK_PERIOD_PS(PERIOD_PS)) u_dut (
        .clk(clk), .rst(rst), .seq_start(seq_start), .seq_stop(seq_stop),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .phy_test_clr(phy_test_clr),
        .phy_shutdown_n(phy_shutdown_n), .phy_rst_n(phy_rst_n),
        .core_rst_n(core_rst_n), .seq_busy(seq_busy), .seq_done(seq_done));

    typedef struct {
        int         c;
        logic [5:0] v;
        string      tag;
    } item_t;

    item_t      q[$];
    int         cyc = 0;
    int         checks = 0;
    int         failures = 0;
    logic [3:0] m = 4'b0000;

    function automatic logic [5:0] actual();
        return {seq_busy, seq_done, phy_test_clr, phy_rst_n, phy_shutdown_n, core_rst_n};
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        while (q.size() > 0 && q[0].c <= cyc) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (it.c < cyc) begin
                failures++;
                $display("FAIL %s missed slot at cycle %0d actual=%b expected=%b", it.tag, it.c, actual(), it.v);
            end else if (actual() !== it.v) begin
                failures++;
                $display("FAIL %s cycle %0d actual=%b expected=%b", it.tag, cyc, actual(), it.v);
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog R2 actual=hung expected=finish");
            finish_run();
        end
    end

    task automatic push(input logic b, input logic d, input string tag);
        item_t it;
        it.c = cyc + 1; it.v = {b, d, m}; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic chk_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            failures++;
            $display("FAIL %s read 0x%h actual=%h expected=%h", tag, a, reg_rdata, exp);
        end
    endtask

    // write; idx is the field index {tclr,phy,shut,ctl}=3..0, -1 for unmapped
    task automatic wr(input logic [7:0] a, input logic b, input int idx, input bit now, input string tag);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = {31'h7fff_fffe, b};
        if (now) begin
            if (idx >= 0) m[idx] = b;
            push(1'b0, 1'b0, tag);
        end
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
    endtask

    // timeline of a full sequence starting at the coming edge; post fields applied after done
    task automatic launch(input logic [3:0] pmask, input logic [3:0] pval);
        item_t it;
        logic [3:0] prev;
        prev = m;
        seq_start = 1'b1;
        for (int k = 0; k <= E + 1; k++) begin
            logic [3:0] v;
            v[0] = (k >= E);
            v[1] = (k == 0) ? prev[1] : (k >= 2 + T);
            v[2] = (k == 0) ? prev[2] : (k >= 2 + T + G);
            v[3] = (k == 0) ? prev[3] : (k >= 1 + T);
            if (k == E + 1) v = (v & ~pmask) | (pval & pmask);
            it.c = cyc + 1 + k;
            it.v = {(k < E), (k == E), v};
            it.tag = (k == 0) ? "R2" : (k <= 1 + T) ? "R3" : (k < E) ? "R4" : (k == E) ? "R5" : "R9";
            q.push_back(it);
            m = v;
        end
        @(negedge clk);
        seq_start = 1'b0;
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        checks++;
        if (actual() !== 6'b000000) begin
            failures++;
            $display("FAIL R1 actual=%b expected=%b", actual(), 6'b000000);
        end

        // R8 writes while idle, R10 readback
        wr(8'h40, 1'b1, 1, 1'b1, "R8");
        chk_rd(8'h40, 32'h1, "R10");
        chk_rd(8'h44, 32'h0, "R10");
        wr(8'h50, 1'b1, 3, 1'b1, "R8");
        wr(8'h44, 1'b1, 2, 1'b1, "R8");
        wr(8'h08, 1'b1, 0, 1'b1, "R8");
        wr(8'h54, 1'b0, -1, 1'b1, "R8");
        chk_rd(8'h54, 32'h0, "R10");
        chk_rd(8'h08, 32'h1, "R10");
        chk_rd(8'h50, 32'h1, "R10");

        // R7 stop while idle
        seq_stop = 1'b1; m[0] = 1'b0; push(1'b0, 1'b0, "R7");
        @(negedge clk);
        seq_stop = 1'b0;
        drain();

        // R2..R5 full sequence from a mixed prior state
        wr(8'h40, 1'b0, 1, 1'b1, "R8");
        launch(4'b0000, 4'b0000);
        drain();

        // R6 start while busy, R12 stop while busy
        launch(4'b0000, 4'b0000);
        @(negedge clk); @(negedge clk);
        seq_start = 1'b1; @(negedge clk); seq_start = 1'b0;
        @(negedge clk);
        seq_stop = 1'b1; @(negedge clk); seq_stop = 1'b0;
        drain();
        chk_rd(8'h08, 32'h1, "R12");

        // R9 writes while busy held, last value per field wins
        launch(4'b1010, 4'b0000);
        @(negedge clk);
        wr(8'h50, 1'b1, 3, 1'b0, "R9");
        wr(8'h50, 1'b0, 3, 1'b0, "R9");
        wr(8'h40, 1'b0, 1, 1'b0, "R9");
        drain();
        chk_rd(8'h40, 32'h0, "R9");

        // R11 write in the same cycle as an accepted start
        reg_wr_en = 1'b1; reg_addr = 8'h44; reg_wdata = 32'h0;
        fork
            launch(4'b0100, 4'b0000);
            begin @(negedge clk); reg_wr_en = 1'b0; end
        join
        drain();
        chk_rd(8'h44, 32'h0, "R11");

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule